// File: doc/BRIEF.md
# Software Interrupt Source Tracker

This block keeps, for every target CPU and every software-generated interrupt number (0 to 15), a small vector with one bit per CPU that has raised that interrupt towards that target. A send request names one source CPU, a mask of target CPUs and an interrupt number, and sets the source's bit in every targeted row at once. The block keeps as many bits as there are CPUs, so several CPUs can signal the same number to the same target and each one is remembered separately.

When a target acknowledges an interrupt number, the block returns an identifier. The identifier holds the lowest-numbered source CPU still recorded for that row, followed by the interrupt number. Only that one source bit is then cleared, so the interrupt stays pending while other sources remain. A clear event drops a whole row. A register port reads a row's source bits and sets or clears them with bitmasks. A flat pending vector, with one bit per row, goes to the priority logic, which is outside this block.

Top module: `sgi_src_track`

## Requirements
- R1: After reset every source bit is zero, so `pend_out` is all zero and every `reg_rdata` read returns zero.
- R2: A send sets bit `send_src` in row (t, `send_num`) for every t whose bit is set in `send_tgt_mask`. Other rows are untouched, and a send with an all-zero mask changes nothing.
- R3: `pend_out[t*16+n]` is high exactly when row (t, n) has at least one source bit set.
- R4: While `ack_valid` is high and row (`ack_tgt`, `ack_num`) is non-empty, `ack_hit` is high. In that case `ack_id[12:10]` is the lowest set source index, `ack_id[9:4]` is zero and `ack_id[3:0]` is `ack_num`.
- R5: An acknowledge with `ack_hit` high clears only the reported source's bit in that row at the next edge. Any other source bits in the row stay set, and so the row stays pending.
- R6: An acknowledge on an empty row gives `ack_hit` low and `ack_id` = 1023, and it changes no state.
- R7: `clr_valid` clears every source bit of row (`clr_tgt`, `clr_num`) at the next edge.
- R8: A send and an acknowledge that hit the same source bit in the same cycle leave that bit set.
- R9: `reg_rdata` shows the source bits of row (`reg_tgt`, `reg_num`) combinationally, with bit s standing for source CPU s.
- R10: `reg_set_we` ORs `reg_wdata` into the selected row, and `reg_clr_we` clears the row bits where `reg_wdata` is one. A set and a clear of the same bit in one cycle leave the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| send_valid | input | 1 | Send request strobe |
| send_src | input | 3 | Sending CPU index |
| send_tgt_mask | input | 8 | One bit per target CPU |
| send_num | input | 4 | Software interrupt number |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_tgt | input | 3 | Acknowledging CPU |
| ack_num | input | 4 | Interrupt number acknowledged |
| ack_hit | output | 1 | Row had a recorded source |
| ack_id | output | 13 | {source[2:0], 6'b0, number[3:0]}, or 1023 when empty |
| clr_valid | input | 1 | Clear-row strobe |
| clr_tgt | input | 3 | Row target for clear |
| clr_num | input | 4 | Row number for clear |
| reg_tgt | input | 3 | Register port row target |
| reg_num | input | 4 | Register port row number |
| reg_set_we | input | 1 | Set-bits write strobe |
| reg_clr_we | input | 1 | Clear-bits write strobe |
| reg_wdata | input | 8 | Source bitmask written |
| reg_rdata | output | 8 | Source bits of the selected row |
| pend_out | output | 128 | Pending flag per (target, number) row |

## Verification
The hardest case to reach is a row holding several sources while an acknowledge meets a send on the very bit it is about to clear. The stimulus builds that state on purpose. Three CPUs signal one number to one target, and the row is then drained one acknowledge at a time, checking the order in which sources are reported. A send is also made to land in the same cycle as the acknowledge of its own bit. A randomized phase then limits interrupt numbers to four values, so that rows collide often.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int ACK_ID_W = 13;
  localparam logic [9:0] NO_IRQ = 10'd1023;

  typedef logic [ACK_ID_W-1:0] ack_id_t;

  // Acknowledge identifier: source in [12:10], interrupt number in [9:0]
  function automatic ack_id_t pack_ack_id(input logic [2:0] src, input logic [9:0] num);
    return {src, num};
  endfunction

  function automatic ack_id_t empty_ack_id();
    return {3'b000, NO_IRQ};
  endfunction
endpackage

// File: rtl/sgi_lowest_enc.sv
module sgi_lowest_enc #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = |vec;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/sgi_src_row.sv
module sgi_src_row #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_m,
  input  logic [N-1:0] clr_m,
  output logic [N-1:0] bits_q
);
  // set wins over clear for the same bit
  always_ff @(posedge clk) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= (bits_q & ~clr_m) | set_m;
  end
endmodule

// File: rtl/sgi_src_track.sv
module sgi_src_track
  import sgi_pkg::*;
#(
  parameter int NCPU = 8,
  parameter int NSGI = 16,
  localparam int CW = $clog2(NCPU),
  localparam int NW = $clog2(NSGI),
  localparam int NROW = NCPU * NSGI
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                send_valid,
  input  logic [CW-1:0]       send_src,
  input  logic [NCPU-1:0]     send_tgt_mask,
  input  logic [NW-1:0]       send_num,
  input  logic                ack_valid,
  input  logic [CW-1:0]       ack_tgt,
  input  logic [NW-1:0]       ack_num,
  output logic                ack_hit,
  output logic [ACK_ID_W-1:0] ack_id,
  input  logic                clr_valid,
  input  logic [CW-1:0]       clr_tgt,
  input  logic [NW-1:0]       clr_num,
  input  logic [CW-1:0]       reg_tgt,
  input  logic [NW-1:0]       reg_num,
  input  logic                reg_set_we,
  input  logic                reg_clr_we,
  input  logic [NCPU-1:0]     reg_wdata,
  output logic [NCPU-1:0]     reg_rdata,
  output logic [NROW-1:0]     pend_out
);
  localparam int RW = CW + NW;

  logic [NCPU-1:0] row_bits [NROW];
  logic [RW-1:0]   ack_row_idx, clr_row_idx, reg_row_idx;
  logic [NCPU-1:0] ack_row;
  logic [CW-1:0]   ack_src;
  logic            ack_any;
  logic            ack_take;   // acknowledge that removes a source bit

  assign ack_row_idx = {ack_tgt, ack_num};
  assign clr_row_idx = {clr_tgt, clr_num};
  assign reg_row_idx = {reg_tgt, reg_num};
  assign ack_row     = row_bits[ack_row_idx];
  assign reg_rdata   = row_bits[reg_row_idx];

  sgi_lowest_enc #(.N(NCPU)) u_enc (
    .vec (ack_row),
    .idx (ack_src),
    .any (ack_any)
  );

  assign ack_take = ack_valid & ack_any;
  assign ack_hit  = ack_take;
  assign ack_id   = ack_take ? pack_ack_id(3'(ack_src), 10'(ack_num)) : empty_ack_id();

  for (genvar t = 0; t < NCPU; t++) begin : g_tgt
    for (genvar n = 0; n < NSGI; n++) begin : g_num
      localparam int R = t * NSGI + n;
      logic [NCPU-1:0] set_m, clr_m;

      always_comb begin
        set_m = '0;
        clr_m = '0;
        if (send_valid && send_tgt_mask[t] && send_num == NW'(n))
          set_m = set_m | (NCPU'(1) << send_src);
        if (reg_set_we && reg_row_idx == RW'(R))
          set_m = set_m | reg_wdata;
        if (reg_clr_we && reg_row_idx == RW'(R))
          clr_m = clr_m | reg_wdata;
        if (clr_valid && clr_row_idx == RW'(R))
          clr_m = '1;
        if (ack_take && ack_row_idx == RW'(R))
          clr_m = clr_m | (NCPU'(1) << ack_src);
      end

      sgi_src_row #(.N(NCPU)) u_row (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_m  (set_m),
        .clr_m  (clr_m),
        .bits_q (row_bits[R])
      );

      assign pend_out[R] = |row_bits[R];
    end
  end
endmodule

// File: rtl/sgi_src_track_chk.sv
module sgi_src_track_chk #(
  parameter int NCPU = 8,
  parameter int NSGI = 16,
  localparam int CW = $clog2(NCPU),
  localparam int NW = $clog2(NSGI),
  localparam int NROW = NCPU * NSGI
) (
  input logic            clk,
  input logic            rst_n,
  input logic            send_valid,
  input logic [CW-1:0]   send_src,
  input logic [NCPU-1:0] send_tgt_mask,
  input logic [NW-1:0]   send_num,
  input logic            ack_valid,
  input logic [CW-1:0]   ack_tgt,
  input logic [NW-1:0]   ack_num,
  input logic            ack_hit,
  input logic [12:0]     ack_id,
  input logic [CW-1:0]   ack_src,
  input logic            clr_valid,
  input logic [CW-1:0]   clr_tgt,
  input logic [NW-1:0]   clr_num,
  input logic [CW-1:0]   reg_tgt,
  input logic [NW-1:0]   reg_num,
  input logic            reg_set_we,
  input logic            reg_clr_we,
  input logic [NCPU-1:0] reg_wdata,
  input logic [NROW-1:0] pend_out,
  input logic [NCPU-1:0] row_bits [NROW]
);
  logic [NCPU-1:0] chk_row;
  assign chk_row = row_bits[{ack_tgt, ack_num}];

  for (genvar t = 0; t < NCPU; t++) begin : g_send
    AST_SEND_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (send_valid && send_tgt_mask[t]) |=> row_bits[{CW'(t), $past(send_num)}][$past(send_src)]); // R2
  end

  AST_ACK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |-> (chk_row[ack_src] && ((chk_row & ((NCPU'(1) << ack_src) - NCPU'(1))) == '0))); // R4

  AST_ACK_LAST_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && $countones(chk_row) == 1 && !send_valid && !reg_set_we)
      |=> !pend_out[$past({ack_tgt, ack_num})]); // R5

  AST_EMPTY_ACK_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_hit) |-> (ack_id == 13'd1023 && chk_row == '0)); // R6

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && !send_valid && !reg_set_we) |=> row_bits[$past({clr_tgt, clr_num})] == '0); // R7

  AST_SEND_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && send_valid && send_tgt_mask[ack_tgt] && send_num == ack_num && send_src == ack_src)
      |=> row_bits[$past({ack_tgt, ack_num})][$past(ack_src)]); // R8

  AST_REG_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_clr_we && !reg_set_we && !send_valid)
      |=> (row_bits[$past({reg_tgt, reg_num})] & $past(reg_wdata)) == '0); // R10
endmodule

bind sgi_src_track sgi_src_track_chk #(.NCPU(NCPU), .NSGI(NSGI)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .send_valid    (send_valid),
  .send_src      (send_src),
  .send_tgt_mask (send_tgt_mask),
  .send_num      (send_num),
  .ack_valid     (ack_valid),
  .ack_tgt       (ack_tgt),
  .ack_num       (ack_num),
  .ack_hit       (ack_hit),
  .ack_id        (ack_id),
  .ack_src       (ack_src),
  .clr_valid     (clr_valid),
  .clr_tgt       (clr_tgt),
  .clr_num       (clr_num),
  .reg_tgt       (reg_tgt),
  .reg_num       (reg_num),
  .reg_set_we    (reg_set_we),
  .reg_clr_we    (reg_clr_we),
  .reg_wdata     (reg_wdata),
  .pend_out      (pend_out),
  .row_bits      (row_bits)
);

// File: tb/sgi_src_track_test.sv
`timescale 1ns/1ps
module sgi_src_track_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         send_valid;
  logic [2:0]   send_src;
  logic [7:0]   send_tgt_mask;
  logic [3:0]   send_num;
  logic         ack_valid;
  logic [2:0]   ack_tgt;
  logic [3:0]   ack_num;
  logic         ack_hit;
  logic [12:0]  ack_id;
  logic         clr_valid;
  logic [2:0]   clr_tgt;
  logic [3:0]   clr_num;
  logic [2:0]   reg_tgt;
  logic [3:0]   reg_num;
  logic         reg_set_we;
  logic         reg_clr_we;
  logic [7:0]   reg_wdata;
  logic [7:0]   reg_rdata;
  logic [127:0] pend_out;

  sgi_src_track uut (.*);

  always #10 clk = ~clk;   // 50 MHz

  typedef struct {
    int    kind;   // 0 rdata, 1 ack_id, 2 ack_hit, 3 pend bit
    int    idx;
    int    exp;
    string tag;
  } item_t;

  item_t    sb[$];
  int       n_tests = 0;
  int       n_fail = 0;
  bit       done = 1'b0;
  logic [7:0] mdl [8][16];

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic push(input int kind, input int idx, input int exp, input string tag);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compares queued expectations away from the clock edge
  initial forever begin
    @(negedge clk);
    #2;
    while (sb.size() > 0) begin
      item_t it;
      int got;
      it = sb.pop_front();
      case (it.kind)
        0: got = int'(reg_rdata);
        1: got = int'(ack_id);
        2: got = int'(ack_hit);
        default: got = int'(pend_out[it.idx]);
      endcase
      n_tests++;
      if (got != it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d idx=%0d got=%0d exp=%0d", it.tag, it.kind, it.idx, got, it.exp);
      end
    end
  end

  task automatic idle_inputs();
    send_valid = 0; send_src = 0; send_tgt_mask = 0; send_num = 0;
    ack_valid = 0; ack_tgt = 0; ack_num = 0;
    clr_valid = 0; clr_tgt = 0; clr_num = 0;
    reg_tgt = 0; reg_num = 0; reg_set_we = 0; reg_clr_we = 0; reg_wdata = 0;
  endtask

  task automatic begin_cyc();
    @(negedge clk);
    idle_inputs();
  endtask

  // bench's own update rule from the requirements, then commit at the edge
  task automatic end_cyc();
    for (int t = 0; t < 8; t++) begin
      for (int n = 0; n < 16; n++) begin
        logic [7:0] s, c;
        s = 0; c = 0;
        if (send_valid && send_tgt_mask[t] && send_num == n) s[send_src] = 1'b1;
        if (reg_set_we && reg_tgt == t && reg_num == n) s = s | reg_wdata;
        if (reg_clr_we && reg_tgt == t && reg_num == n) c = c | reg_wdata;
        if (clr_valid && clr_tgt == t && clr_num == n) c = 8'hFF;
        if (ack_valid && ack_tgt == t && ack_num == n && mdl[t][n] != 0) c[lowest(mdl[t][n])] = 1'b1;
        mdl[t][n] = (mdl[t][n] & ~c) | s;
      end
    end
    @(posedge clk);
  endtask

  task automatic send(input int src, input int mask, input int num);
    send_valid = 1; send_src = 3'(src); send_tgt_mask = 8'(mask); send_num = 4'(num);
  endtask

  task automatic ack(input int t, input int n, input string tag);
    int lo;
    ack_valid = 1; ack_tgt = 3'(t); ack_num = 4'(n);
    lo = lowest(mdl[t][n]);
    push(2, 0, (lo >= 0) ? 1 : 0, tag);
    push(1, 0, (lo >= 0) ? ((lo << 10) | n) : 1023, tag);
  endtask

  task automatic chk_read(input int t, input int n, input string tag);
    reg_tgt = 3'(t); reg_num = 4'(n);
    push(0, 0, int'(mdl[t][n]), tag);
  endtask

  task automatic chk_pend(input int t, input int n, input string tag);
    push(3, t * 16 + n, (mdl[t][n] != 0) ? 1 : 0, tag);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(20.0 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < 8; t++) for (int n = 0; n < 16; n++) mdl[t][n] = 0;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1 reset state, R6 acknowledge of an empty row
    begin_cyc(); chk_read(0, 0, "R1 rdata"); chk_pend(0, 0, "R1 pend"); chk_pend(7, 15, "R1 pend"); end_cyc();
    begin_cyc(); chk_read(7, 15, "R1 rdata"); ack(3, 3, "R6 empty ack"); end_cyc();
    begin_cyc(); chk_read(3, 3, "R6 no change"); end_cyc();

    // R2 send to targets 1 and 4
    begin_cyc(); send(5, 8'b0001_0010, 3); end_cyc();
    begin_cyc(); chk_read(1, 3, "R2 tgt1"); chk_pend(1, 3, "R3 pend"); chk_pend(0, 3, "R3 idle"); end_cyc();
    begin_cyc(); chk_read(4, 3, "R2 tgt4"); chk_pend(4, 3, "R3 pend"); end_cyc();
    begin_cyc(); chk_read(0, 3, "R2 untargeted"); send(6, 0, 5); end_cyc();
    begin_cyc(); chk_read(0, 5, "R2 zero mask"); chk_pend(0, 5, "R2 zero mask pend"); end_cyc();

    // several sources on one row
    begin_cyc(); send(2, 8'b0000_0010, 3); end_cyc();
    begin_cyc(); send(7, 8'b0000_0010, 3); end_cyc();
    begin_cyc(); chk_read(1, 3, "R9 three sources"); end_cyc();

    // R4 lowest source first, R5 one bit at a time
    begin_cyc(); ack(1, 3, "R4 src2"); end_cyc();
    begin_cyc(); chk_read(1, 3, "R5 after ack"); chk_pend(1, 3, "R5 still pending"); end_cyc();
    begin_cyc(); ack(1, 3, "R4 src5"); end_cyc();
    begin_cyc(); ack(1, 3, "R4 src7"); end_cyc();
    begin_cyc(); chk_read(1, 3, "R5 drained"); chk_pend(1, 3, "R5 not pending"); chk_pend(4, 3, "R5 other target"); end_cyc();

    // R8 send and acknowledge on the same bit
    begin_cyc(); send(0, 8'b0000_0100, 9); end_cyc();
    begin_cyc(); ack(2, 9, "R8 ack id"); send(0, 8'b0000_0100, 9); end_cyc();
    begin_cyc(); chk_read(2, 9, "R8 bit kept"); chk_pend(2, 9, "R8 pending"); end_cyc();

    // R7 row clear, with number 15 in the id field
    begin_cyc(); reg_tgt = 6; reg_num = 15; reg_set_we = 1; reg_wdata = 8'h3C; end_cyc();
    begin_cyc(); ack(6, 15, "R4 num15"); end_cyc();
    begin_cyc(); chk_read(6, 15, "R5 row 6/15"); clr_valid = 1; clr_tgt = 6; clr_num = 15; end_cyc();
    begin_cyc(); chk_read(6, 15, "R7 cleared"); chk_pend(6, 15, "R7 pend"); chk_pend(2, 9, "R7 other row"); end_cyc();

    // R10 register set / clear bitmasks
    begin_cyc(); reg_tgt = 0; reg_num = 0; reg_set_we = 1; reg_wdata = 8'h81; end_cyc();
    begin_cyc(); chk_read(0, 0, "R10 set"); end_cyc();
    begin_cyc(); reg_tgt = 0; reg_num = 0; reg_clr_we = 1; reg_wdata = 8'h01; end_cyc();
    begin_cyc(); chk_read(0, 0, "R10 clear"); end_cyc();
    begin_cyc(); reg_tgt = 0; reg_num = 0; reg_clr_we = 1; reg_set_we = 1; reg_wdata = 8'h80; end_cyc();
    begin_cyc(); chk_read(0, 0, "R10 set beats clear"); ack(0, 0, "R4 src7 row0"); end_cyc();
    begin_cyc(); chk_read(0, 0, "R5 row0 empty"); end_cyc();

    // randomized traffic on few numbers to force collisions
    for (int k = 0; k < 400; k++) begin
      begin_cyc();
      if ($urandom_range(0, 1) == 1) send($urandom_range(0, 7), $urandom_range(0, 255), $urandom_range(0, 3));
      if ($urandom_range(0, 2) == 0) ack($urandom_range(0, 7), $urandom_range(0, 3), "R4 random ack");
      if ($urandom_range(0, 9) == 0) begin clr_valid = 1; clr_tgt = 3'($urandom_range(0, 7)); clr_num = 4'($urandom_range(0, 3)); end
      chk_read($urandom_range(0, 7), $urandom_range(0, 3), "R9 random read");
      chk_pend($urandom_range(0, 7), $urandom_range(0, 3), "R3 random pend");
      end_cyc();
    end

    begin_cyc(); end_cyc();
    begin_cyc(); end_cyc();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule